// File: doc/BRIEF.md
# EEPROM Transfer Sequencer over a Byte-Level Two-Wire Engine

This block runs complete EEPROM transfers as a bus master. It sits above a byte-level two-wire (I2C) engine that handles the bit timing. It takes one request at a time, made of:

- a 7-bit device address,
- a one-byte word address,
- a direction,
- a length,
- three flags: send the word address, random read, and acknowledge polling.

From that request it drives the engine through a short command port and reacts to each status event the engine returns. Bytes to be written come in on a ready/valid stream. Bytes that are read leave on a valid-only stream. A `done` pulse marks the end of every transfer, and a sticky `error` flag marks transfers that failed.

A random read starts as a write that carries the word address. The block then sends a repeated START and addresses the device again for reading. With acknowledge polling on, a device that refuses its address (for example while it is busy with an internal write cycle) is addressed again, up to a parameter limit. When a transfer fails, or the engine reports a fault, the block resets the engine and frees itself.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `rd_valid`, `wr_ready` and `eng_cmd_valid` are all low.
- R2: A request is taken only when `req_valid` is high and `busy` is low. Taking it raises `busy` in the next cycle and issues a START (op 1). A `req_valid` seen while `busy` is high is ignored.
- R3: Each START-sent event (status code 0) is answered with a WRITE command (op 2) of the address byte. The address byte is the device address in bits 7:1 and the R/W bit in bit 0 (1 = read).
- R4: When `req_send_word` or `req_rand_read` is set, the word address is written exactly once, right after the first acknowledged address byte.
- R5: A random read sends its first address byte with R/W = 0 and then the word address. After that byte is acknowledged it issues a new START, and the next address byte carries R/W = 1.
- R6: In a write, each acknowledged byte (status code 1, ack bit = 1) is followed by the next byte taken from the write stream, until `req_len` bytes have been sent. The acknowledge of the last byte is followed by STOP (op 5), then a `done` pulse, with `busy` low in that same cycle.
- R7: In a read, every byte except the last is requested with READ-ACK (op 3) and the last with READ-NACK (op 4). Each received byte (status code 2) appears once on `rd_data` with a one-cycle `rd_valid`. The last byte is followed by STOP and `done`.
- R8: A `req_len` of 0 means 256 bytes. Exactly that many bytes are read, and only the last one gets NACK.
- R9: With polling on, a NACKed byte causes a fresh START, up to MAX_POLL retries. The NACK after the last permitted retry is a failure.
- R10: A NACK with polling off, an exhausted retry budget, or a fault event (status code 3) issues RESET (op 6). After it come `done`, `busy` low and `error` high.
- R11: `error` stays high after a failure until the next request is taken, and taking a request clears it.
- R12: `eng_cmd_valid` is a strobe that never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_dev | input | 7 | Device address |
| req_word | input | 8 | Word address inside the device |
| req_read | input | 1 | 1 = read direction |
| req_len | input | LEN_W | Byte count, 0 means 2**LEN_W |
| req_send_word | input | 1 | Send the word address after the device address |
| req_rand_read | input | 1 | Random read: write word address, then repeated START and read |
| req_poll | input | 1 | Retry a NACKed byte with a new START |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| error | output | 1 | Sticky failure flag |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |
| eng_cmd_valid | output | 1 | Engine command strobe |
| eng_cmd_op | output | 3 | Engine opcode: 1 START, 2 WRITE, 3 READ-ACK, 4 READ-NACK, 5 STOP, 6 RESET |
| eng_cmd_data | output | 8 | Byte to transmit with WRITE |
| eng_sts_valid | input | 1 | Engine status strobe |
| eng_sts_code | input | 2 | 0 START sent, 1 byte sent, 2 byte received, 3 fault |
| eng_sts_ack | input | 1 | Acknowledge seen for a sent byte (1 = ACK) |
| eng_sts_data | input | 8 | Received byte |

## Verification
The bench plays the engine together with a behavioural EEPROM. The EEPROM keeps an internal address pointer and can NACK its address for a set number of attempts.

- A multi-byte write followed by a random read of the same locations shows that the word address and the repeated START are placed correctly and that the stored bytes return in order.
- A 256-byte current-address read isolates the length-zero encoding and the single NACK on the final byte.
- A one-byte read isolates the case where the first read is already the last.
- Three runs against an absent or busy device separate polling that succeeds, polling that runs out of retries, and a plain NACK without polling.
- A run with an injected engine fault, and a second request raised while busy, confirm that faults reset the engine and that requests during a transfer have no effect.

// File: rtl/eexfer_pkg.sv
package eexfer_pkg;

  localparam int DEV_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_WRITE   = 3'd2,
    OP_RD_ACK  = 3'd3,
    OP_RD_NACK = 3'd4,
    OP_STOP    = 3'd5,
    OP_RESET   = 3'd6
  } eng_op_e;

  typedef enum logic [1:0] {
    EV_STARTED = 2'd0,
    EV_SENT    = 2'd1,
    EV_RCVD    = 2'd2,
    EV_FAULT   = 2'd3
  } eng_ev_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FETCH = 2'd3
  } seq_state_e;

endpackage

// File: rtl/eexfer_byte_cnt.sv
module eexfer_byte_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             clr,
  input  logic             inc,
  output logic             at_end,
  output logic             last_one,
  output logic             last_two
);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << LEN_W;

  logic [CW-1:0] total_q, total_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    total_d = total_q;
    cnt_d   = cnt_q;
    if (load) begin
      total_d = (len_in == '0) ? FULL : {1'b0, len_in};
      cnt_d   = '0;
    end else if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= CW'(1);
      cnt_q   <= '0;
    end else begin
      total_q <= total_d;
      cnt_q   <= cnt_d;
    end
  end

  assign at_end   = (cnt_q == total_q);
  assign last_one = ((cnt_q + CW'(1)) == total_q);
  assign last_two = ((cnt_q + CW'(2)) == total_q);

  // R8: the byte counter never runs past the requested total
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= total_q);

endmodule

// File: rtl/eexfer_poll_ctr.sv
module eexfer_poll_ctr #(
  parameter int MAX_POLL = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int PW = $clog2(MAX_POLL + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_POLL);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != LIMIT)) begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign spent = (cnt_q == LIMIT);

  // R9: retries stay within the configured budget
  assert_poll_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

endmodule

// File: rtl/eexfer_ctrl.sv
module eexfer_ctrl
  import eexfer_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [BYTE_W-1:0] req_word,
  input  logic              req_read,
  input  logic              req_send_word,
  input  logic              req_rand_read,
  input  logic              req_poll,
  output logic              busy,
  output logic              done,
  output logic              error,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              eng_cmd_valid,
  output logic [2:0]        eng_cmd_op,
  output logic [BYTE_W-1:0] eng_cmd_data,
  input  logic              eng_sts_valid,
  input  logic [1:0]        eng_sts_code,
  input  logic              eng_sts_ack,
  input  logic [BYTE_W-1:0] eng_sts_data,
  output logic              cnt_load,
  output logic              cnt_clr,
  output logic              cnt_inc,
  input  logic              cnt_at_end,
  input  logic              cnt_last_one,
  input  logic              cnt_last_two,
  output logic              poll_clr,
  output logic              poll_inc,
  input  logic              poll_spent
);

  seq_state_e        state_q, state_d;
  eng_op_e           op_q, op_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic [BYTE_W-1:0] word_q, word_d;
  logic              rw_q, rw_d;
  logic              wsend_q, wsend_d;
  logic              rand_q, rand_d;
  logic              poll_q, poll_d;
  logic              restart_q, restart_d;
  logic              final_q, final_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic              rdv_q, rdv_d;
  logic [BYTE_W-1:0] rdd_q, rdd_d;
  logic              take_req;
  logic              sts_in_wait;

  assign take_req    = (state_q == ST_IDLE) && req_valid;
  assign sts_in_wait = (state_q == ST_WAIT) && eng_sts_valid;

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    dat_d     = dat_q;
    dev_d     = dev_q;
    word_d    = word_q;
    rw_d      = rw_q;
    wsend_d   = wsend_q;
    rand_d    = rand_q;
    poll_d    = poll_q;
    restart_d = restart_q;
    final_d   = final_q;
    err_d     = err_q;
    done_d    = 1'b0;
    rdv_d     = 1'b0;
    rdd_d     = rdd_q;
    cnt_load  = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    wr_ready  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (take_req) begin
          dev_d     = req_dev;
          word_d    = req_word;
          rw_d      = req_read & ~req_rand_read;
          wsend_d   = req_send_word | req_rand_read;
          rand_d    = req_rand_read;
          poll_d    = req_poll;
          restart_d = 1'b0;
          final_d   = 1'b0;
          err_d     = 1'b0;
          cnt_load  = 1'b1;
          poll_clr  = 1'b1;
          op_d      = OP_START;
          state_d   = ST_ISSUE;
        end
      end

      ST_ISSUE: begin
        if (final_q) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (op_q == OP_RESET) err_d = 1'b1;
        end else begin
          state_d = ST_WAIT;
        end
      end

      ST_WAIT: begin
        if (eng_sts_valid) begin
          state_d = ST_ISSUE;
          unique case (eng_ev_e'(eng_sts_code))
            EV_STARTED: begin
              op_d    = OP_WRITE;
              dat_d   = {dev_q, rw_q};
              cnt_clr = 1'b1;
            end
            EV_SENT: begin
              if (eng_sts_ack) begin
                if (restart_q) begin
                  restart_d = 1'b0;
                  op_d      = OP_START;
                end else if (wsend_q) begin
                  wsend_d = 1'b0;
                  op_d    = OP_WRITE;
                  dat_d   = word_q;
                  if (rand_q) begin
                    restart_d = 1'b1;
                    rw_d      = 1'b1;
                  end
                end else if (!rw_q) begin
                  if (cnt_at_end) begin
                    op_d    = OP_STOP;
                    final_d = 1'b1;
                  end else begin
                    state_d = ST_FETCH;
                  end
                end else begin
                  op_d = cnt_last_one ? OP_RD_NACK : OP_RD_ACK;
                end
              end else if (poll_q && !poll_spent) begin
                poll_inc = 1'b1;
                op_d     = OP_START;
              end else begin
                op_d    = OP_RESET;
                final_d = 1'b1;
              end
            end
            EV_RCVD: begin
              rdv_d   = 1'b1;
              rdd_d   = eng_sts_data;
              cnt_inc = 1'b1;
              if (cnt_last_one) begin
                op_d    = OP_STOP;
                final_d = 1'b1;
              end else begin
                op_d = cnt_last_two ? OP_RD_NACK : OP_RD_ACK;
              end
            end
            default: begin
              op_d    = OP_RESET;
              final_d = 1'b1;
            end
          endcase
        end
      end

      ST_FETCH: begin
        wr_ready = 1'b1;
        if (wr_valid) begin
          op_d    = OP_WRITE;
          dat_d   = wr_data;
          cnt_inc = 1'b1;
          state_d = ST_ISSUE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_NONE;
      dat_q     <= '0;
      dev_q     <= '0;
      word_q    <= '0;
      rw_q      <= 1'b0;
      wsend_q   <= 1'b0;
      rand_q    <= 1'b0;
      poll_q    <= 1'b0;
      restart_q <= 1'b0;
      final_q   <= 1'b0;
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      rdv_q     <= 1'b0;
      rdd_q     <= '0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      dat_q     <= dat_d;
      dev_q     <= dev_d;
      word_q    <= word_d;
      rw_q      <= rw_d;
      wsend_q   <= wsend_d;
      rand_q    <= rand_d;
      poll_q    <= poll_d;
      restart_q <= restart_d;
      final_q   <= final_d;
      err_q     <= err_d;
      done_q    <= done_d;
      rdv_q     <= rdv_d;
      rdd_q     <= rdd_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign error         = err_q;
  assign rd_valid      = rdv_q;
  assign rd_data       = rdd_q;
  assign eng_cmd_valid = (state_q == ST_ISSUE);
  assign eng_cmd_op    = op_q;
  assign eng_cmd_data  = dat_q;

  // R2: busy only rises right after a request strobe
  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R3: a START-sent event is followed by the address byte write
  assert_addr_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sts_in_wait && (eng_sts_code == EV_STARTED))
      |-> eng_cmd_valid && (eng_cmd_op == OP_WRITE) && (eng_cmd_data[7:1] == dev_q));

  // R6: done comes with busy already low, and only at the end of a transfer
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  // R7: every read strobe follows a received-byte event
  assert_rd_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_sts_valid && (eng_sts_code == EV_RCVD)));

  // R10: error only rises right after a RESET command
  assert_err_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(eng_cmd_valid && (eng_cmd_op == OP_RESET)));

  // R11: error only clears when a new request is taken
  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(error) |-> $past(req_valid && !busy));

  // R12: command strobe lasts one cycle
  assert_cmd_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |=> !eng_cmd_valid);

endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
  import eexfer_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int MAX_POLL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_word,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_send_word,
  input  logic             req_rand_read,
  input  logic             req_poll,
  output logic             busy,
  output logic             done,
  output logic             error,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             eng_cmd_valid,
  output logic [2:0]       eng_cmd_op,
  output logic [7:0]       eng_cmd_data,
  input  logic             eng_sts_valid,
  input  logic [1:0]       eng_sts_code,
  input  logic             eng_sts_ack,
  input  logic [7:0]       eng_sts_data
);

  logic rst_meta_q, rst_sync_q;
  logic cnt_load, cnt_clr, cnt_inc;
  logic cnt_at_end, cnt_last_one, cnt_last_two;
  logic poll_clr, poll_inc, poll_spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  eexfer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .req_valid     (req_valid),
    .req_dev       (req_dev),
    .req_word      (req_word),
    .req_read      (req_read),
    .req_send_word (req_send_word),
    .req_rand_read (req_rand_read),
    .req_poll      (req_poll),
    .busy          (busy),
    .done          (done),
    .error         (error),
    .wr_data       (wr_data),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_op    (eng_cmd_op),
    .eng_cmd_data  (eng_cmd_data),
    .eng_sts_valid (eng_sts_valid),
    .eng_sts_code  (eng_sts_code),
    .eng_sts_ack   (eng_sts_ack),
    .eng_sts_data  (eng_sts_data),
    .cnt_load      (cnt_load),
    .cnt_clr       (cnt_clr),
    .cnt_inc       (cnt_inc),
    .cnt_at_end    (cnt_at_end),
    .cnt_last_one  (cnt_last_one),
    .cnt_last_two  (cnt_last_two),
    .poll_clr      (poll_clr),
    .poll_inc      (poll_inc),
    .poll_spent    (poll_spent)
  );

  eexfer_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (cnt_load),
    .len_in   (req_len),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .at_end   (cnt_at_end),
    .last_one (cnt_last_one),
    .last_two (cnt_last_two)
  );

  eexfer_poll_ctr #(.MAX_POLL(MAX_POLL)) u_poll (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .spent (poll_spent)
  );

endmodule

// File: tb/eeprom_xfer_seq_test.sv
module eeprom_xfer_seq_test;

  localparam logic [6:0] DEV = 7'h50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [6:0] req_dev = '0;
  logic [7:0] req_word = '0;
  logic       req_read = 1'b0;
  logic [7:0] req_len = '0;
  logic       req_send_word = 1'b0;
  logic       req_rand_read = 1'b0;
  logic       req_poll = 1'b0;
  logic       busy, done, error;
  logic [7:0] wr_data = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       eng_cmd_valid;
  logic [2:0] eng_cmd_op;
  logic [7:0] eng_cmd_data;
  logic       eng_sts_valid = 1'b0;
  logic [1:0] eng_sts_code = '0;
  logic       eng_sts_ack = 1'b0;
  logic [7:0] eng_sts_data = '0;

  eeprom_xfer_seq #(.LEN_W(8), .MAX_POLL(4)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural EEPROM + engine
  logic [7:0] mem [0:255];
  logic [7:0] ptr = '0;
  int phase = 0;            // 0 idle, 1 address, 2 word addr, 3 data
  int busy_left = 0;
  bit inject_fault = 0;
  int starts = 0, stops = 0, resets = 0, rd_acks = 0, rd_nacks = 0, dbl_cmd = 0;
  logic [7:0] addr_log [0:15];
  logic [7:0] wbuf [0:7];
  int widx = 0;
  bit hs_pend = 0;
  logic [7:0] exp_q [$];
  int rd_seen = 0;

  task automatic clear_stats();
    starts = 0; stops = 0; resets = 0; rd_acks = 0; rd_nacks = 0;
    widx = 0; rd_seen = 0;
  endtask

  initial begin : responder
    bit prev_cmd;
    prev_cmd = 0;
    forever begin
      @(negedge clk);
      eng_sts_valid = 1'b0;
      if (eng_cmd_valid && prev_cmd) dbl_cmd++;
      prev_cmd = eng_cmd_valid;
      if (eng_cmd_valid) begin
        logic [1:0] code;
        logic ack;
        logic [7:0] rdat;
        bit reply;
        reply = 1; ack = 0; rdat = '0; code = 2'd0;
        case (eng_cmd_op)
          3'd1: begin
            phase = 1;
            if (starts < 16) addr_log[starts] = 8'hFF;
            starts++;
            code = inject_fault ? 2'd3 : 2'd0;
            inject_fault = 0;
          end
          3'd2: begin
            code = 2'd1;
            if (phase == 1) begin
              if (starts <= 16) addr_log[starts-1] = eng_cmd_data;
              if (eng_cmd_data[7:1] == DEV && busy_left == 0) begin
                ack = 1;
                phase = eng_cmd_data[0] ? 3 : 2;
              end else begin
                if (eng_cmd_data[7:1] == DEV) busy_left--;
                phase = 0;
              end
            end else if (phase == 2) begin
              ptr = eng_cmd_data; ack = 1; phase = 3;
            end else if (phase == 3) begin
              mem[ptr] = eng_cmd_data; ptr++; ack = 1;
            end
          end
          3'd3, 3'd4: begin
            code = 2'd2; rdat = mem[ptr]; ptr++;
            if (eng_cmd_op == 3'd3) rd_acks++; else rd_nacks++;
          end
          3'd5: begin stops++; reply = 0; phase = 0; end
          default: begin resets++; reply = 0; phase = 0; end
        endcase
        if (reply) begin
          repeat (2) @(negedge clk);
          prev_cmd = 0;
          eng_sts_code = code; eng_sts_ack = ack; eng_sts_data = rdat;
          eng_sts_valid = 1'b1;
        end
      end
    end
  end

  // write stream feeder
  initial begin : feeder
    forever begin
      @(negedge clk);
      if (hs_pend) widx++;
      wr_data = wbuf[widx % 8];
      hs_pend = wr_valid && wr_ready;
    end
  end

  // scoreboard monitor
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        rd_seen++;
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected read byte", rd_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R7 read data", rd_data, e);
        end
      end
    end
  end

  task automatic push_exp(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic xfer(input logic [6:0] dev, input logic [7:0] wa, input bit rd,
                      input logic [7:0] len, input bit sw, input bit rr, input bit pl,
                      input bit poke);
    @(negedge clk);
    req_dev = dev; req_word = wa; req_read = rd; req_len = len;
    req_send_word = sw; req_rand_read = rr; req_poll = pl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_dev = 7'h22; req_read = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
    wbuf[4] = 8'hA4; wbuf[5] = 8'hA5; wbuf[6] = 8'hA6; wbuf[7] = 8'hA7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!busy && !done && !error && !rd_valid && !wr_ready && !eng_cmd_valid,
          "R1 reset outputs", {busy, done, error, rd_valid, wr_ready, eng_cmd_valid}, 0);

    // sequential write of 4 bytes at 0x10 (R3 R4 R6)
    clear_stats(); wr_valid = 1'b1;
    xfer(DEV, 8'h10, 0, 8'd4, 1, 0, 0, 0);
    wr_valid = 1'b0;
    check(!busy, "R6 busy low with done", busy, 0);
    check(addr_log[0] == {DEV, 1'b0}, "R3 write address byte", addr_log[0], {DEV, 1'b0});
    check(mem[8'h10] == 8'hA0 && mem[8'h13] == 8'hA3, "R6 written bytes", mem[8'h13], 8'hA3);
    check(widx == 4, "R6 stream bytes taken", widx, 4);
    check(stops == 1 && starts == 1, "R6 single stop", stops, 1);
    check(ptr == 8'h14, "R4 word address sent once", ptr, 8'h14);
    check(!error, "R6 no error", error, 0);

    // random read 4 bytes at 0x10 (R5 R7)
    clear_stats();
    for (int i = 0; i < 4; i++) push_exp(8'hA0 + 8'(i));
    xfer(DEV, 8'h10, 1, 8'd4, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    check(starts == 2, "R5 repeated start", starts, 2);
    check(addr_log[0] == {DEV, 1'b0}, "R5 first address write", addr_log[0], {DEV, 1'b0});
    check(addr_log[1] == {DEV, 1'b1}, "R5 second address read", addr_log[1], {DEV, 1'b1});
    check(rd_acks == 3 && rd_nacks == 1, "R7 ack/nack split", rd_acks, 3);
    check(rd_seen == 4 && exp_q.size() == 0, "R7 all bytes out", rd_seen, 4);

    // polling succeeds after 3 NACKs (R9)
    clear_stats(); busy_left = 3; wr_valid = 1'b1;
    xfer(DEV, 8'h40, 0, 8'd2, 1, 0, 1, 0);
    wr_valid = 1'b0;
    check(starts == 4, "R9 poll restarts", starts, 4);
    check(!error && resets == 0, "R9 poll success no error", error, 0);
    check(mem[8'h40] == 8'hA0 && mem[8'h41] == 8'hA1, "R9 data after poll", mem[8'h41], 8'hA1);

    // polling exhausted (R9 R10 R11)
    clear_stats(); busy_left = 100;
    xfer(DEV, 8'h40, 0, 8'd1, 1, 0, 1, 0);
    @(negedge clk);
    check(starts == 5, "R9 retry cap", starts, 5);
    check(error && resets == 1 && !busy, "R10 reset after exhaust", resets, 1);
    repeat (10) @(negedge clk);
    check(error == 1'b1, "R11 error sticky", error, 1);

    // NACK without polling (R10)
    clear_stats(); busy_left = 1;
    xfer(DEV, 8'h40, 0, 8'd1, 1, 0, 0, 0);
    @(negedge clk);
    check(starts == 1 && resets == 1 && error, "R10 nack no poll", starts, 1);
    busy_left = 0;

    // engine fault (R10)
    clear_stats(); inject_fault = 1;
    xfer(DEV, 8'h40, 1, 8'd1, 0, 1, 0, 0);
    @(negedge clk);
    check(resets == 1 && error && stops == 0, "R10 fault reset", resets, 1);

    // one-byte random read clears error (R11 R7)
    clear_stats(); push_exp(8'hA0);
    xfer(DEV, 8'h40, 1, 8'd1, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    check(!error, "R11 error cleared by new request", error, 0);
    check(rd_acks == 0 && rd_nacks == 1, "R7 single byte nack", rd_nacks, 1);

    // second request while busy is ignored (R2)
    clear_stats(); wr_valid = 1'b1;
    xfer(DEV, 8'h60, 0, 8'd3, 1, 0, 0, 1);
    wr_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(starts == 1 && !busy, "R2 busy request ignored", starts, 1);
    check(mem[8'h62] == 8'hA2, "R2 first request completed", mem[8'h62], 8'hA2);

    // length 0 = 256 current-address read (R8)
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    ptr = 8'h00;
    clear_stats();
    for (int i = 0; i < 256; i++) push_exp(8'(i) ^ 8'h5A);
    xfer(DEV, 8'h00, 1, 8'd0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(rd_seen == 256, "R8 256 bytes read", rd_seen, 256);
    check(rd_acks == 255 && rd_nacks == 1, "R8 nack only last", rd_nacks, 1);
    check(addr_log[0] == {DEV, 1'b1}, "R3 read address byte", addr_log[0], {DEV, 1'b1});

    check(dbl_cmd == 0, "R12 command strobe single cycle", dbl_cmd, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule